// File: doc/BRIEF.md
# Register-Field Instruction Morpher

This block sits on the handshake between instruction fetch and instruction decode of a 64-bit core. Each fetched 32-bit word may have its register specifiers (destination, first source, second source) replaced while the word travels to decode. Opcode, function codes and immediates are never altered, and no words are inserted or dropped. The PC stream seen by the front end is therefore unchanged. The block produces varied, hazard-rich instruction streams from a fixed stimulus program while the core runs.

Three parts cooperate. A 16-bit LFSR supplies random register numbers. A small replay table remembers, for each (word, PC) pair already seen, the word that was sent out, so that a replay of the same pair yields the same result and an external reference model can track the stream. A short FIFO holds the destination registers of instructions issued and not yet retired. Rewritten fields are often drawn from this FIFO, which creates read-after-write and write-after-write hazards on purpose. With `enable` low the block is a plain wire with no added cycle.

Top module: `insn_morpher`

## Requirements
- R1: With `enable` low and nothing held, `d_valid` equals `f_valid`, `d_word` equals `f_word`, and `f_ready` equals `d_ready`, all in the same cycle. Neither debug flag is raised. A word passed this way is not entered into the replay table.
- R2: With `enable` high, a word accepted at a clock edge appears on `d_word` with `d_valid` high after that edge, and never in the cycle it is offered. While `d_valid` is high and `d_ready` is low, `d_word` stays stable and `f_ready` is low.
- R3: The field in bits [11:7] (destination), bits [19:15] (first source) and bits [24:20] (second source) may be rewritten. Which of them is decided by opcode bits [6:0]. Opcodes 0x33, 0x3B and 0x2F rewrite all three. Opcodes 0x13, 0x1B, 0x03 and 0x67 rewrite destination and first source. Opcodes 0x23 and 0x63 rewrite both sources. Opcodes 0x37, 0x17 and 0x6F rewrite the destination only. Every other opcode passes unchanged. All bits outside the rewritable fields match the fetched word.
- R4: A (word, PC) pair that is still held in the replay table gets back the exact word it produced before, with `dbg_from_map` high. A pair not in the table (including the same word at another PC) gets `dbg_from_map` low and is entered into the table.
- R5: The replay table holds 8 pairs and replaces them in round-robin order. After 9 distinct misses following a flush, the first pair is gone and pairs 2 to 9 still hit.
- R6: A pulse on `flush` empties the replay table, so a pair held before the pulse misses afterwards.
- R7: The hazard window holds up to 4 destination registers in issue order. An enabled issue pushes the emitted destination field if its format has one and it is not register 0. When full, a push drops the oldest entry. Each `retire` pulse removes the oldest entry, and a pulse on an empty window is ignored.
- R8: Each rewritten field takes an LFSR value when the window is empty. Otherwise one LFSR bit selects either a window entry or a random register, so a large share of rewritten fields name a register still in the window.
- R9: `dbg_morphed` is high exactly when `d_valid` is high and `d_word` differs from the fetched word it came from. `dbg_from_map` is high when the emitted word came from a replay-table hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Morphing on; low gives direct pass-through |
| flush | input | 1 | Empties the replay table |
| f_valid | input | 1 | Fetch side word valid |
| f_ready | output | 1 | Block can take the fetch word |
| f_word | input | 32 | Fetched instruction word |
| f_pc | input | 64 | Address of the fetched word |
| retire | input | 1 | One instruction left the pipeline |
| d_valid | output | 1 | Decode side word valid |
| d_ready | input | 1 | Decode can take the word |
| d_word | output | 32 | Word sent to decode |
| dbg_morphed | output | 1 | Emitted word differs from the fetched one |
| dbg_from_map | output | 1 | Emitted word came from a replay-table hit |

## Verification
The hardest behaviour to reach from the ports is the hazard selection. The register chosen depends on the LFSR state and on the current window contents, and neither is visible. The bench keeps its own copy of the window, built only from emitted destination fields and retire pulses. It spaces retires so the window stays mostly full over a near-exhaustive sweep of every opcode class. It then measures how often a rewritten field names a register that is still in flight. Round-robin eviction is reached by a flush followed by exactly nine distinct pairs. The survivors are then replayed before the evicted one.

// File: rtl/morph_pkg.sv
package morph_pkg;

    localparam int ILEN   = 32;
    localparam int RW     = 5;
    localparam int RD_LO  = 7;
    localparam int RS1_LO = 15;
    localparam int RS2_LO = 20;
    localparam int NFLD   = 3;

    typedef logic [RW-1:0] reg_idx_t;

    typedef struct packed {
        logic has_rs2;
        logic has_rs1;
        logic has_rd;
    } fmt_t;

    typedef struct packed {
        logic [ILEN-1:0] word;
        logic [ILEN-1:0] orig;
        logic            hit;
    } stage_t;

    // Register fields present for each major opcode.
    function automatic fmt_t fields_of(input logic [6:0] opc);
        fmt_t f;
        f = '0;
        case (opc)
            7'b0110011, 7'b0111011, 7'b0101111:
                f = '{has_rs2: 1'b1, has_rs1: 1'b1, has_rd: 1'b1};
            7'b0010011, 7'b0011011, 7'b0000011, 7'b1100111:
                f = '{has_rs2: 1'b0, has_rs1: 1'b1, has_rd: 1'b1};
            7'b0100011, 7'b1100011:
                f = '{has_rs2: 1'b1, has_rs1: 1'b1, has_rd: 1'b0};
            7'b0110111, 7'b0010111, 7'b1101111:
                f = '{has_rs2: 1'b0, has_rs1: 1'b0, has_rd: 1'b1};
            default:
                f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/morph_lfsr.sv
module morph_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ TAPS[WIDTH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED[WIDTH-1:0];
        else if (step) state <= nxt;
    end

    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/morph_rd_window.sv
module morph_rd_window #(
    parameter int DEPTH = 4,
    parameter int RW    = 5,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic [RW-1:0]             push_rd,
    input  logic                      pop,
    output logic [DEPTH-1:0][RW-1:0]  entries,
    output logic [CW-1:0]             count
);

    logic [DEPTH-1:0][RW-1:0] nxt;
    logic [CW-1:0]            ncnt;

    always_comb begin
        nxt  = entries;
        ncnt = count;
        // Drop the head on a retire, or to make room when full.
        if ((pop && count != '0) || (push && count == CW'(DEPTH))) begin
            for (int i = 0; i < DEPTH - 1; i++) nxt[i] = nxt[i+1];
            ncnt = ncnt - 1'b1;
        end
        if (push) begin
            nxt[ncnt[IW-1:0]] = push_rd;
            ncnt = ncnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            entries <= '0;
        end else begin
            count   <= ncnt;
            entries <= nxt;
        end
    end

    p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_head_not_x0_r7: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (entries[0] != '0));

    p_empty_retire_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> (count == '0));

endmodule

// File: rtl/morph_replay_map.sv
module morph_replay_map #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 96,
    parameter int VAL_W   = 32,
    localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [VAL_W-1:0] lk_val,
    input  logic             ins_en,
    input  logic [VAL_W-1:0] ins_val
);

    logic [ENTRIES-1:0]            vld;
    logic [ENTRIES-1:0]            hit_vec;
    logic [ENTRIES-1:0][KEY_W-1:0] keys;
    logic [ENTRIES-1:0][VAL_W-1:0] vals;
    logic [PW-1:0]                 ptr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (keys[g] == lk_key);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_val = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) lk_val = lk_val | vals[i];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (ins_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == PW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush && !rst) begin
            keys[ptr] <= lk_key;
            vals[ptr] <= ins_val;
        end
    end

    p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld == '0));

endmodule

// File: rtl/insn_morpher.sv
module insn_morpher
    import morph_pkg::*;
#(
    parameter int          XLEN        = 64,
    parameter int          MAP_ENTRIES = 8,
    parameter int          WIN_DEPTH   = 4,
    parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            flush,
    input  logic            f_valid,
    output logic            f_ready,
    input  logic [ILEN-1:0] f_word,
    input  logic [XLEN-1:0] f_pc,
    input  logic            retire,
    output logic            d_valid,
    input  logic            d_ready,
    output logic [ILEN-1:0] d_word,
    output logic            dbg_morphed,
    output logic            dbg_from_map
);

    localparam int KEY_W = ILEN + XLEN;
    localparam int CW    = $clog2(WIN_DEPTH + 1);
    localparam int IW    = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
    localparam int LW    = 16;

    stage_t                         st_q;
    logic                           ovq;
    logic                           accept;
    fmt_t                           fmt;
    logic                           map_hit;
    logic [ILEN-1:0]                map_val;
    logic [ILEN-1:0]                mut_word;
    logic [ILEN-1:0]                new_word;
    logic [LW-1:0]                  lfsr;
    logic [WIN_DEPTH-1:0][RW-1:0]   win_regs;
    logic [CW-1:0]                  win_cnt;
    logic                           win_push;

    // Handshake: one optional register stage, pass-through when disabled.
    assign f_ready = enable ? (!ovq || d_ready) : (!ovq && d_ready);
    assign accept  = enable && f_valid && f_ready;
    assign d_valid = ovq || (!enable && f_valid);
    assign d_word  = ovq ? st_q.word : f_word;

    assign dbg_morphed  = d_valid && (d_word != (ovq ? st_q.orig : f_word));
    assign dbg_from_map = ovq && st_q.hit;

    assign fmt = fields_of(f_word[6:0]);

    morph_lfsr #(.WIDTH(LW), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (accept && !map_hit),
        .state (lfsr)
    );

    morph_replay_map #(.ENTRIES(MAP_ENTRIES), .KEY_W(KEY_W), .VAL_W(ILEN)) u_map (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .lk_key  ({f_word, f_pc}),
        .lk_hit  (map_hit),
        .lk_val  (map_val),
        .ins_en  (accept && !map_hit),
        .ins_val (mut_word)
    );

    assign win_push = accept && fmt.has_rd && (new_word[RD_LO +: RW] != '0);

    morph_rd_window #(.DEPTH(WIN_DEPTH), .RW(RW)) u_win (
        .clk     (clk),
        .rst     (rst),
        .push    (win_push),
        .push_rd (new_word[RD_LO +: RW]),
        .pop     (retire),
        .entries (win_regs),
        .count   (win_cnt)
    );

    // Per-field register choice: each field sees a rotated view of the LFSR.
    for (genvar g = 0; g < NFLD; g++) begin : g_pick
        logic [2*LW-1:0] dbl;
        logic [LW-1:0]   rot;
        logic [IW-1:0]   idx;
        reg_idx_t        sel;
        always_comb begin
            dbl = {lfsr, lfsr} >> (5 * g);
            rot = dbl[LW-1:0];
            idx = '0;
            if (win_cnt == '0 || !rot[0]) begin
                sel = rot[RW:1];
            end else begin
                idx = IW'(32'(rot[RW+1 +: IW]) % 32'(win_cnt));
                sel = win_regs[idx];
            end
        end
    end

    always_comb begin
        mut_word = f_word;
        if (fmt.has_rd)  mut_word[RD_LO  +: RW] = g_pick[0].sel;
        if (fmt.has_rs1) mut_word[RS1_LO +: RW] = g_pick[1].sel;
        if (fmt.has_rs2) mut_word[RS2_LO +: RW] = g_pick[2].sel;
        new_word = map_hit ? map_val : mut_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovq  <= 1'b0;
            st_q <= '0;
        end else if (accept) begin
            ovq  <= 1'b1;
            st_q <= '{word: new_word, orig: f_word, hit: map_hit};
        end else if (d_ready) begin
            ovq  <= 1'b0;
        end
    end

    p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (ovq && !d_ready) |=> (ovq && $stable(st_q)));

    p_opcode_kept_r3: assert property (@(posedge clk) disable iff (rst)
        ovq |-> (st_q.word[6:0] == st_q.orig[6:0]));

    p_change_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (ovq && st_q.word == st_q.orig) |-> !dbg_morphed);

endmodule

// File: tb/sim_insn_morpher.sv
module sim_insn_morpher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        flush = 1'b0;
    logic        f_valid = 1'b0;
    logic        retire = 1'b0;
    logic        d_ready = 1'b1;
    logic [31:0] f_word = '0;
    logic [63:0] f_pc = '0;
    logic        f_ready, d_valid, dbg_morphed, dbg_from_map;
    logic [31:0] d_word;

    always #10 clk = ~clk;

    insn_morpher u0 (
        .clk(clk), .rst(rst), .enable(enable), .flush(flush),
        .f_valid(f_valid), .f_ready(f_ready), .f_word(f_word), .f_pc(f_pc),
        .retire(retire), .d_valid(d_valid), .d_ready(d_ready), .d_word(d_word),
        .dbg_morphed(dbg_morphed), .dbg_from_map(dbg_from_map)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [4:0] mw [4];
    int mcnt = 0;
    int haz_tot = 0;
    int haz_hit = 0;
    int n_changed = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {second source, first source, destination} per opcode class
    function automatic logic [2:0] tb_fields(input logic [6:0] opc);
        if (opc == 7'h33 || opc == 7'h3B || opc == 7'h2F) return 3'b111;
        if (opc == 7'h13 || opc == 7'h1B || opc == 7'h03 || opc == 7'h67) return 3'b011;
        if (opc == 7'h23 || opc == 7'h63) return 3'b110;
        if (opc == 7'h37 || opc == 7'h17 || opc == 7'h6F) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [31:0] tb_mask(input logic [2:0] f);
        logic [31:0] m;
        m = '0;
        if (f[0]) m = m | 32'h0000_0F80;
        if (f[1]) m = m | 32'h000F_8000;
        if (f[2]) m = m | 32'h01F0_0000;
        return m;
    endfunction

    function automatic bit in_model(input logic [4:0] r);
        for (int i = 0; i < mcnt; i++) if (mw[i] == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_push(input logic [4:0] r);
        if (mcnt == 4) begin
            for (int i = 0; i < 3; i++) mw[i] = mw[i+1];
            mcnt = 3;
        end
        mw[mcnt] = r;
        mcnt++;
    endtask

    task automatic retire_pulse();
        @(negedge clk);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        if (mcnt > 0) begin
            for (int i = 0; i < 3; i++) mw[i] = mw[i+1];
            mcnt--;
        end
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic account(input logic [31:0] w, input logic [31:0] got, input logic hit);
        logic [2:0] f;
        f = tb_fields(w[6:0]);
        if (!hit && mcnt > 0) begin
            if (f[0]) begin haz_tot++; if (in_model(got[11:7]))  haz_hit++; end
            if (f[1]) begin haz_tot++; if (in_model(got[19:15])) haz_hit++; end
            if (f[2]) begin haz_tot++; if (in_model(got[24:20])) haz_hit++; end
        end
        if (got != w) n_changed++;
        if (f[0] && got[11:7] != 5'd0) model_push(got[11:7]);
    endtask

    task automatic issue(input logic [31:0] w, input logic [63:0] pc,
                         output logic [31:0] got, output logic hit);
        logic [31:0] m;
        logic chg;
        @(negedge clk);
        f_word = w; f_pc = pc; f_valid = 1'b1;
        #1;
        chk(d_valid == 1'b0, "R2 no same-cycle output", 64'(d_valid), 64'd0);
        @(negedge clk);
        got = d_word; hit = dbg_from_map; chg = dbg_morphed;
        f_valid = 1'b0;
        chk(d_valid == 1'b1, "R2 output after one edge", 64'(d_valid), 64'd1);
        chk(chg == (got != w), "R9 morph flag", 64'(chg), 64'(got != w));
        m = tb_mask(tb_fields(w[6:0]));
        chk((got & ~m) == (w & ~m), "R3 fixed bits kept", 64'(got), 64'(w));
        account(w, got, hit);
    endtask

    task automatic bypass_one(input logic [31:0] w, input logic [63:0] pc);
        @(negedge clk);
        enable = 1'b0; f_word = w; f_pc = pc; f_valid = 1'b1; d_ready = 1'b1;
        #1;
        chk(d_valid == 1'b1, "R1 valid passes", 64'(d_valid), 64'd1);
        chk(d_word == w, "R1 word passes", 64'(d_word), 64'(w));
        chk(!dbg_morphed && !dbg_from_map, "R1 debug quiet", 64'({dbg_morphed, dbg_from_map}), 64'd0);
        chk(f_ready == 1'b1, "R1 ready follows", 64'(f_ready), 64'd1);
        d_ready = 1'b0;
        #1;
        chk(f_ready == 1'b0, "R1 ready follows low", 64'(f_ready), 64'd0);
        d_ready = 1'b1;
        f_valid = 1'b0;
        #1;
        chk(d_valid == 1'b0, "R1 valid follows low", 64'(d_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0]  opcs [16];
        logic [31:0] w, got, got2, held, wa, wb;
        logic [31:0] rec [9];
        logic        hit;
        opcs = '{7'h33, 7'h3B, 7'h2F, 7'h13, 7'h1B, 7'h03, 7'h67, 7'h23,
                 7'h63, 7'h37, 7'h17, 7'h6F, 7'h73, 7'h0F, 7'h07, 7'h53};

        // Reset state
        repeat (3) @(negedge clk);
        chk(d_valid == 1'b0, "R1 reset no output", 64'(d_valid), 64'd0);
        chk(!dbg_morphed && !dbg_from_map, "R9 reset debug low", 64'({dbg_morphed, dbg_from_map}), 64'd0);
        rst = 1'b0;

        // R1: pass-through over every opcode class
        for (int i = 0; i < 16; i++)
            bypass_one({7'(i * 3), 5'(i), 5'(i + 2), 3'(i), 5'(i * 5), opcs[i]}, 64'h4000 + 64'(4 * i));

        // R1: bypassed pair leaves no trace in the table
        flush_pulse();
        bypass_one(32'h0031_02B3, 64'h9000);
        @(negedge clk); enable = 1'b1;
        issue(32'h0031_02B3, 64'h9000, got, hit);
        chk(hit == 1'b0, "R1 bypass not recorded", 64'(hit), 64'd0);

        // R3/R8/R9: sweep of all opcode classes with distinct PCs
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 12; k++) begin
                w = {7'(k * 5 + i), 5'(k * 3 + 1), 5'(k + i), 3'(k), 5'(i * 7 + k), opcs[i]};
                issue(w, 64'h1_0000 + 64'(4 * (i * 12 + k)), got, hit);
                chk(hit == 1'b0, "R4 new pair misses", 64'(hit), 64'd0);
                if (tb_fields(opcs[i]) == 3'b000)
                    chk(got == w, "R3 no-field opcode exact", 64'(got), 64'(w));
                if (k % 3 == 2) retire_pulse();
            end
        end
        chk(haz_tot > 20 && haz_hit * 4 > haz_tot, "R8 window reuse rate",
            64'(haz_hit), 64'(haz_tot / 4));
        chk(n_changed > 0, "R8 fields rewritten", 64'(n_changed), 64'd1);

        // R7: extra retires on an empty window, then refill
        repeat (7) retire_pulse();
        chk(mcnt == 0, "R7 model drained", 64'(mcnt), 64'd0);
        for (int k = 0; k < 6; k++) begin
            issue({7'd0, 5'(k), 5'(k + 9), 3'd0, 5'(k + 1), 7'h33}, 64'h2_0000 + 64'(4 * k), got, hit);
            chk(hit == 1'b0, "R7 refill misses", 64'(hit), 64'd0);
        end

        // R4: replay determinism
        flush_pulse();
        for (int k = 0; k < 8; k++) begin
            issue({7'h20, 5'(k), 5'(k + 4), 3'd0, 5'(k + 8), 7'h33}, 64'h3_0000 + 64'(4 * k), rec[k], hit);
            chk(hit == 1'b0, "R4 first sight misses", 64'(hit), 64'd0);
        end
        for (int k = 0; k < 8; k++) begin
            issue({7'h20, 5'(k), 5'(k + 4), 3'd0, 5'(k + 8), 7'h33}, 64'h3_0000 + 64'(4 * k), got, hit);
            chk(hit == 1'b1, "R4 replay hits", 64'(hit), 64'd1);
            chk(got == rec[k], "R4 replay identical", 64'(got), 64'(rec[k]));
        end

        // R6: flush forgets
        flush_pulse();
        issue({7'h20, 5'd0, 5'd4, 3'd0, 5'd8, 7'h33}, 64'h3_0000, got, hit);
        chk(hit == 1'b0, "R6 flushed pair misses", 64'(hit), 64'd0);

        // R4/R5: same word elsewhere misses; round-robin eviction
        flush_pulse();
        for (int k = 0; k < 9; k++) begin
            issue(32'h0041_8513, 64'h5_0000 + 64'(4 * k), rec[k], hit);
            chk(hit == 1'b0, "R4 same word new PC misses", 64'(hit), 64'd0);
        end
        for (int k = 2; k < 9; k++) begin
            issue(32'h0041_8513, 64'h5_0000 + 64'(4 * k), got, hit);
            chk(hit == 1'b1, "R5 survivor hits", 64'(hit), 64'd1);
            chk(got == rec[k], "R5 survivor identical", 64'(got), 64'(rec[k]));
        end
        issue(32'h0041_8513, 64'h5_0000, got2, hit);
        chk(hit == 1'b0, "R5 oldest evicted", 64'(hit), 64'd0);

        // R2: backpressure hold, then release with a new word behind it
        wa = 32'h00B5_0633;
        wb = 32'h0000_0073;
        @(negedge clk);
        d_ready = 1'b0; f_word = wa; f_pc = 64'h6_0000; f_valid = 1'b1;
        @(negedge clk);
        held = d_word;
        chk(d_valid == 1'b1, "R2 held valid", 64'(d_valid), 64'd1);
        f_word = wb; f_pc = 64'h6_0004;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(d_word == held, "R2 word stable under stall", 64'(d_word), 64'(held));
            chk(f_ready == 1'b0, "R2 fetch stalled", 64'(f_ready), 64'd0);
            chk(d_valid == 1'b1, "R2 valid kept under stall", 64'(d_valid), 64'd1);
        end
        account(wa, held, 1'b0);
        d_ready = 1'b1;
        @(negedge clk);
        f_valid = 1'b0;
        chk(d_valid == 1'b1, "R2 next word follows", 64'(d_valid), 64'd1);
        chk(d_word == wb, "R2 next word exact", 64'(d_word), 64'(wb));
        chk(dbg_morphed == 1'b0, "R9 unchanged word not flagged", 64'(dbg_morphed), 64'd0);
        @(negedge clk);
        chk(d_valid == 1'b0, "R2 drained", 64'(d_valid), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule